// File: doc/BRIEF.md
# Sized Execution Unit with Five Condition Flags

This block is the arithmetic and shift engine of a 32-bit data path with variable operand widths. Each operation takes a destination operand, a source operand, an operand-size code, an operation code and the current condition flags. It returns a new 32-bit destination value, an updated five-bit flag vector and a divide-overflow indication. For byte and word operations the new destination value keeps the upper bits of the old destination, so the caller writes the result straight back into its register file.

The unit is driven by a small controller. It waits in `ST_IDLE`. A `start` seen in `ST_IDLE` latches the operands. Every operation except unsigned divide then moves to `ST_CALC`, which computes the result in one cycle, and from there to `ST_DONE`. Divide moves to `ST_DIV_CHK` instead. If the divide would overflow, `ST_DIV_CHK` goes straight to `ST_DONE`. Otherwise it loads an iterative divider and moves to `ST_DIV_RUN`, which stays until the divider has produced one quotient bit per cycle and then goes to `ST_DONE`. `ST_DONE` always returns to `ST_IDLE`. The outputs hold their values until the next operation finishes.

The flag vector is ordered X (bit 4), N (bit 3), Z (bit 2), V (bit 1), C (bit 0). Operation codes: 0 add, 1 subtract, 2 compare, 3 add-to-address, 4 unsigned multiply, 5 unsigned divide, 6 half swap, 7 logical left shift, 8 logical right shift, 9 arithmetic left shift, 10 arithmetic right shift, 11 rotate left, 12 rotate right. Size codes: 0 byte, 1 word, 2 or 3 long. Every shift or rotate moves the operand by exactly one bit position.

Top module: `sized_exec_unit`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `ccr` and `div_ovf` are all zero.
- R2: `start` is accepted only while `busy` is low. A `start` that arrives while `busy` is high has no effect. `done` is a one-cycle pulse. A non-divide operation raises `done` on the second clock edge after the edge that accepted it. A divide finishes within 20 edges. Codes 13 to 15 return the destination unchanged and copy `ccr_in` to `ccr`.
- R3: For byte (size 0) and word (size 1) add, subtract and shift operations, only bits 7:0 or 15:0 of the destination change. N and Z are taken from the sized result.
- R4: Add sets C to the carry out of the sized MSB and sets X equal to C. V is set when both operands have the same sign and the result has the other sign.
- R5: Subtract computes destination minus source. C and X are set to the borrow. V is set when the operands have different signs and the result sign differs from the destination sign.
- R6: Compare applies the subtract rules to N, Z, V and C. It returns the destination unchanged and keeps X from `ccr_in`.
- R7: Add-to-address adds the source to the full 32-bit destination. With size 0 or 1 the source is first sign-extended from 16 bits. It returns `ccr_in` unchanged.
- R8: Multiply forms the 32-bit unsigned product of the two low halves. It sets N and Z from the product, clears V and C, and keeps X.
- R9: Divide puts the remainder in bits 31:16 and the quotient in bits 15:0. N is quotient bit 15, Z is set for a zero quotient, V and C are cleared, and X is kept.
- R10: A zero divisor, or a destination upper half greater than or equal to the divisor, raises `div_ovf` and sets V. It also clears C, keeps X, N and Z, and returns the destination unchanged.
- R11: Swap exchanges the two 16-bit halves. It sets N and Z from the 32-bit result, clears V and C, and keeps X.
- R12: Logical shifts feed in a zero. C and X receive the bit shifted out, and V is cleared.
- R13: Arithmetic right shift copies the sign bit into the vacated top bit. Arithmetic left shift feeds in a zero and sets V when the sized sign bit changes. C and X receive the bit shifted out.
- R14: Rotates feed the outgoing bit into the opposite end. C receives that bit, X is kept, and V is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an operation; sampled while idle |
| op | input | 4 | Operation code |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| dst | input | 32 | Destination operand (old register value) |
| src | input | 32 | Source operand |
| ccr_in | input | 5 | Current flags {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Merged destination value |
| ccr | output | 5 | New flags {X,N,Z,V,C} |
| div_ovf | output | 1 | Divide overflow or zero divisor |

## Verification
A controller stuck in the wrong state shows up at the ports within the expected latency. Either `done` never pulses, it pulses twice, or it arrives on the wrong edge. For this reason every operation is timed from the accept edge. A corrupt partial remainder in the divider cannot stay hidden: it reaches both halves of the result in the same `done` cycle, so each divide is checked for both remainder and quotient. Errors in lane selection or flag routing show up in the same cycle as stray upper bits or a wrong flag bit. The byte, word and long cases, and the checks that X is kept, catch these.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
    localparam int DW = 32;
    localparam int HW = DW / 2;
    localparam int FW = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_ADDA = 4'd3,
        OP_MULU = 4'd4,
        OP_DIVU = 4'd5,
        OP_SWAP = 4'd6,
        OP_LSL  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ASL  = 4'd9,
        OP_ASR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12
    } sxu_op_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
        logic [DW-1:0] m;
        case (sz)
            SZ_BYTE: m = DW'(8'hFF);
            SZ_WORD: m = DW'(16'hFFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [DW-1:0] merge_sized(input logic [DW-1:0] old_v,
                                                  input logic [DW-1:0] new_v,
                                                  input logic [1:0]    sz);
        logic [DW-1:0] m;
        m = size_mask(sz);
        return (old_v & ~m) | (new_v & m);
    endfunction

    function automatic logic sized_msb(input logic [DW-1:0] v, input logic [1:0] sz);
        logic b;
        case (sz)
            SZ_BYTE: b = v[7];
            SZ_WORD: b = v[15];
            default: b = v[DW-1];
        endcase
        return b;
    endfunction

    function automatic logic sized_zero(input logic [DW-1:0] v, input logic [1:0] sz);
        return (v & size_mask(sz)) == '0;
    endfunction

    function automatic logic [1:0] lane_index(input logic [1:0] sz);
        return (sz == SZ_BYTE) ? 2'd0 : (sz == SZ_WORD) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/sxu_arith.sv
module sxu_arith
    import sxu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [1:0]    size,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  ccr_t          ccr_in,
    output logic [DW-1:0] res,
    output ccr_t          ccr
);
    localparam int LANES = 3;

    logic          is_sub;
    logic [DW-1:0] opnd_b;
    logic [DW-1:0] lane_sum [LANES];
    logic          lane_cy  [LANES];
    logic          lane_v   [LANES];
    logic [1:0]    lidx;
    logic [DW-1:0] sum_sz;
    logic          cy_sz;
    logic          v_sz;
    logic          c_flag;
    logic [DW-1:0] adda_src;
    logic [DW-1:0] adda_sum;
    logic [DW-1:0] prod;

    assign is_sub = (op == OP_SUB) || (op == OP_CMP);
    assign opnd_b = is_sub ? ~src : src;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int W = 8 << gi;
        logic [W:0] s;
        assign s = {1'b0, dst[W-1:0]} + {1'b0, opnd_b[W-1:0]} + {{W{1'b0}}, is_sub};
        assign lane_sum[gi] = DW'(s[W-1:0]);
        assign lane_cy[gi]  = s[W];
        assign lane_v[gi]   = (dst[W-1] == opnd_b[W-1]) && (s[W-1] != dst[W-1]);
    end

    assign lidx    = lane_index(size);
    assign sum_sz  = lane_sum[lidx];
    assign cy_sz   = lane_cy[lidx];
    assign v_sz    = lane_v[lidx];
    assign c_flag  = is_sub ? ~cy_sz : cy_sz;

    assign adda_src = size[1] ? src : {{HW{src[HW-1]}}, src[HW-1:0]};
    assign adda_sum = dst + adda_src;
    assign prod     = DW'(dst[HW-1:0]) * DW'(src[HW-1:0]);

    always_comb begin
        res = dst;
        ccr = ccr_in;
        case (op)
            OP_ADD, OP_SUB: begin
                res   = merge_sized(dst, sum_sz, size);
                ccr.x = c_flag;
                ccr.n = sized_msb(sum_sz, size);
                ccr.z = sized_zero(sum_sz, size);
                ccr.v = v_sz;
                ccr.c = c_flag;
            end
            OP_CMP: begin
                res   = dst;
                ccr.n = sized_msb(sum_sz, size);
                ccr.z = sized_zero(sum_sz, size);
                ccr.v = v_sz;
                ccr.c = c_flag;
            end
            OP_ADDA: begin
                res = adda_sum;
            end
            OP_MULU: begin
                res   = prod;
                ccr.n = prod[DW-1];
                ccr.z = (prod == '0);
                ccr.v = 1'b0;
                ccr.c = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sxu_shift.sv
module sxu_shift
    import sxu_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [1:0]    size,
    input  logic [DW-1:0] dst,
    input  ccr_t          ccr_in,
    output logic [DW-1:0] res,
    output ccr_t          ccr
);
    localparam int LANES = 3;

    logic [DW-1:0] lane_res [LANES];
    logic          lane_out [LANES];
    logic          lane_vf  [LANES];
    logic [1:0]    lidx;
    logic [DW-1:0] r_sz;
    logic          is_rot;
    logic [DW-1:0] swapped;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int W = 8 << gi;
        logic [W-1:0] v;
        logic [W-1:0] r;
        logic         o;
        logic         vf;
        assign v = dst[W-1:0];
        always_comb begin
            r  = v;
            o  = 1'b0;
            vf = 1'b0;
            case (op)
                OP_LSL: begin r = {v[W-2:0], 1'b0};    o = v[W-1]; end
                OP_ASL: begin r = {v[W-2:0], 1'b0};    o = v[W-1]; vf = v[W-1] ^ v[W-2]; end
                OP_LSR: begin r = {1'b0, v[W-1:1]};    o = v[0];   end
                OP_ASR: begin r = {v[W-1], v[W-1:1]};  o = v[0];   end
                OP_ROL: begin r = {v[W-2:0], v[W-1]};  o = v[W-1]; end
                OP_ROR: begin r = {v[0], v[W-1:1]};    o = v[0];   end
                default: ;
            endcase
        end
        assign lane_res[gi] = DW'(r);
        assign lane_out[gi] = o;
        assign lane_vf[gi]  = vf;
    end

    assign lidx    = lane_index(size);
    assign r_sz    = lane_res[lidx];
    assign is_rot  = (op == OP_ROL) || (op == OP_ROR);
    assign swapped = {dst[HW-1:0], dst[DW-1:HW]};

    always_comb begin
        res = dst;
        ccr = ccr_in;
        case (op)
            OP_SWAP: begin
                res   = swapped;
                ccr.n = swapped[DW-1];
                ccr.z = (swapped == '0);
                ccr.v = 1'b0;
                ccr.c = 1'b0;
            end
            OP_LSL, OP_LSR, OP_ASL, OP_ASR, OP_ROL, OP_ROR: begin
                res   = merge_sized(dst, r_sz, size);
                ccr.n = sized_msb(r_sz, size);
                ccr.z = sized_zero(r_sz, size);
                ccr.v = lane_vf[lidx];
                ccr.c = lane_out[lidx];
                ccr.x = is_rot ? ccr_in.x : lane_out[lidx];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sxu_divider.sv
module sxu_divider #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [2*QW-1:0] dividend,
    input  logic [QW-1:0] divisor,
    output logic [QW-1:0] quot,
    output logic [QW-1:0] rem,
    output logic          fin
);
    localparam int CW = $clog2(QW) + 1;

    logic [QW-1:0] rem_q;
    logic [QW-1:0] quo_q;
    logic [QW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic [QW:0]   trial;
    logic [QW:0]   diff;
    logic          ge;

    assign trial = {rem_q, quo_q[QW-1]};
    assign diff  = trial - {1'b0, dvs_q};
    assign ge    = (trial >= {1'b0, dvs_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            fin   <= 1'b0;
        end else if (load) begin
            rem_q <= dividend[2*QW-1:QW];
            quo_q <= dividend[QW-1:0];
            dvs_q <= divisor;
            cnt_q <= '0;
            fin   <= 1'b0;
        end else if (run && !fin) begin
            rem_q <= ge ? diff[QW-1:0] : trial[QW-1:0];
            quo_q <= {quo_q[QW-2:0], ge};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(QW - 1)) begin
                fin <= 1'b1;
            end
        end
    end

    assign quot = quo_q;
    assign rem  = rem_q;
endmodule

// File: rtl/sized_exec_unit.sv
module sized_exec_unit
    import sxu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [1:0]    size,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [FW-1:0] ccr_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [FW-1:0] ccr,
    output logic          div_ovf
);
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_DIV_CHK,
        ST_DIV_RUN,
        ST_DONE
    } state_e;

    state_e        state_q;
    state_e        state_d;

    logic [3:0]    op_q;
    logic [1:0]    size_q;
    logic [DW-1:0] dst_q;
    logic [DW-1:0] src_q;
    ccr_t          ccr_q;

    logic [DW-1:0] ar_res;
    ccr_t          ar_ccr;
    logic [DW-1:0] sh_res;
    ccr_t          sh_ccr;
    logic          use_shift;
    logic [DW-1:0] calc_res;
    ccr_t          calc_ccr;

    logic          div_bad;
    logic          div_load;
    logic          div_run;
    logic [HW-1:0] div_quot;
    logic [HW-1:0] div_rem;
    logic          div_fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            size_q <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            ccr_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            op_q   <= op;
            size_q <= size;
            dst_q  <= dst;
            src_q  <= src;
            ccr_q  <= ccr_t'(ccr_in);
        end
    end

    sxu_arith u_arith (
        .op     (op_q),
        .size   (size_q),
        .dst    (dst_q),
        .src    (src_q),
        .ccr_in (ccr_q),
        .res    (ar_res),
        .ccr    (ar_ccr)
    );

    sxu_shift u_shift (
        .op     (op_q),
        .size   (size_q),
        .dst    (dst_q),
        .ccr_in (ccr_q),
        .res    (sh_res),
        .ccr    (sh_ccr)
    );

    assign use_shift = (op_q >= OP_SWAP) && (op_q <= OP_ROR);
    assign calc_res  = use_shift ? sh_res : ar_res;
    assign calc_ccr  = use_shift ? sh_ccr : ar_ccr;

    assign div_bad  = (src_q[HW-1:0] == '0) || (dst_q[DW-1:HW] >= src_q[HW-1:0]);
    assign div_load = (state_q == ST_DIV_CHK) && !div_bad;
    assign div_run  = (state_q == ST_DIV_RUN);

    sxu_divider #(.QW(HW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .run      (div_run),
        .dividend (dst_q),
        .divisor  (src_q[HW-1:0]),
        .quot     (div_quot),
        .rem      (div_rem),
        .fin      (div_fin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (op == OP_DIVU) ? ST_DIV_CHK : ST_CALC;
            end
            ST_CALC:    state_d = ST_DONE;
            ST_DIV_CHK: state_d = div_bad ? ST_DONE : ST_DIV_RUN;
            ST_DIV_RUN: if (div_fin) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            ccr     <= '0;
            div_ovf <= 1'b0;
        end else begin
            case (state_q)
                ST_CALC: begin
                    result  <= calc_res;
                    ccr     <= calc_ccr;
                    div_ovf <= 1'b0;
                end
                ST_DIV_CHK: begin
                    if (div_bad) begin
                        result  <= dst_q;
                        ccr     <= {ccr_q.x, ccr_q.n, ccr_q.z, 1'b1, 1'b0};
                        div_ovf <= 1'b1;
                    end
                end
                ST_DIV_RUN: begin
                    if (div_fin) begin
                        result  <= {div_rem, div_quot};
                        ccr     <= {ccr_q.x, div_quot[HW-1], (div_quot == '0), 1'b0, 1'b0};
                        div_ovf <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done = (state_q == ST_DONE);
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sxu_checker.sv
module sxu_checker
    import sxu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [3:0]    op,
    input logic [1:0]    size,
    input logic [DW-1:0] dst,
    input logic [DW-1:0] src,
    input logic [FW-1:0] ccr_in,
    input logic [DW-1:0] result,
    input logic [FW-1:0] ccr,
    input logic          div_ovf
);
    logic [3:0]    cap_op;
    logic [1:0]    cap_size;
    logic [DW-1:0] cap_dst;
    logic [DW-1:0] cap_src;
    logic [FW-1:0] cap_ccr;
    logic          cap_sized_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op   <= '0;
            cap_size <= '0;
            cap_dst  <= '0;
            cap_src  <= '0;
            cap_ccr  <= '0;
        end else if (start && !busy) begin
            cap_op   <= op;
            cap_size <= size;
            cap_dst  <= dst;
            cap_src  <= src;
            cap_ccr  <= ccr_in;
        end
    end

    assign cap_sized_op = (cap_op == OP_ADD) || (cap_op == OP_SUB) ||
                          ((cap_op >= OP_LSL) && (cap_op <= OP_ROR));

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R2
    AST_BYTE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_sized_op && cap_size == SZ_BYTE) |-> (result[DW-1:8] == cap_dst[DW-1:8])); // R3
    AST_WORD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_sized_op && cap_size == SZ_WORD) |-> (result[DW-1:16] == cap_dst[DW-1:16])); // R3
    AST_CMP_KEEPS_DST_X: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op == OP_CMP) |-> (result == cap_dst && ccr[4] == cap_ccr[4])); // R6
    AST_ADDRESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op == OP_ADDA) |-> (ccr == cap_ccr)); // R7
    AST_MULU_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op == OP_MULU) |-> (ccr[1:0] == 2'b00 && !div_ovf)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_ovf) |-> (cap_op == OP_DIVU && ccr[1] && result == cap_dst)); // R10
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op == OP_DIVU && cap_src[15:0] == '0) |-> div_ovf); // R10
    AST_ROTATE_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_op == OP_ROL || cap_op == OP_ROR)) |-> (ccr[4] == cap_ccr[4])); // R14
endmodule

bind sized_exec_unit sxu_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .op      (op),
    .size    (size),
    .dst     (dst),
    .src     (src),
    .ccr_in  (ccr_in),
    .result  (result),
    .ccr     (ccr),
    .div_ovf (div_ovf)
);

// File: tb/sized_exec_unit_test.sv
module sized_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] dst = '0;
    logic [31:0] src = '0;
    logic [4:0]  ccr_in = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic [4:0]  ccr;
    logic        div_ovf;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sized_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .dst(dst), .src(src), .ccr_in(ccr_in), .busy(busy), .done(done),
        .result(result), .ccr(ccr), .div_ovf(div_ovf)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic [1:0] s, input logic [31:0] d,
                          input logic [31:0] sr, input logic [4:0] ci, output int lat);
        @(negedge clk);
        op = o; size = s; dst = d; src = sr; ccr_in = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_op(input string req, input logic [3:0] o, input logic [1:0] s,
                             input logic [31:0] d, input logic [31:0] sr, input logic [4:0] ci,
                             input logic [31:0] exp_r, input logic [4:0] exp_f, input logic exp_ov);
        int lat;
        run_op(o, s, d, sr, ci, lat);
        chk({req, " result"}, result, exp_r);
        chk({req, " flags"}, 32'(ccr), 32'(exp_f));
        chk({req, " div_ovf"}, 32'(div_ovf), 32'(exp_ov));
        if (o == 4'd5) chk("R2 divide latency<=20", 32'(lat <= 20), 32'd1);
        else           chk("R2 latency", 32'(lat), 32'd2);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 result", result, 0);
        chk("R1 ccr", 32'(ccr), 0);
        chk("R1 div_ovf", 32'(div_ovf), 0);
    endtask

    task automatic t_add();
        expect_op("R4 add byte", 4'd0, 2'd0, 32'h22334455, 32'h12345678, 5'h00, 32'h223344CD, 5'h0A, 1'b0);
        expect_op("R4 add word", 4'd0, 2'd1, 32'h22334455, 32'h12345678, 5'h00, 32'h22339ACD, 5'h0A, 1'b0);
        expect_op("R4 add long", 4'd0, 2'd2, 32'h22334455, 32'h12345678, 5'h1F, 32'h34679ACD, 5'h00, 1'b0);
        expect_op("R3 add byte carry", 4'd0, 2'd0, 32'hAB0000FF, 32'h00000001, 5'h00, 32'hAB000000, 5'h15, 1'b0);
    endtask

    task automatic t_sub();
        expect_op("R5 sub word borrow", 4'd1, 2'd1, 32'h00000003, 32'h00000005, 5'h00, 32'h0000FFFE, 5'h19, 1'b0);
        expect_op("R5 sub byte overflow", 4'd1, 2'd0, 32'hAABBCC80, 32'h00000001, 5'h00, 32'hAABBCC7F, 5'h02, 1'b0);
    endtask

    task automatic t_cmp();
        expect_op("R6 cmp keeps X", 4'd2, 2'd1, 32'hABCD0005, 32'h00000003, 5'h10, 32'hABCD0005, 5'h10, 1'b0);
        expect_op("R6 cmp equal", 4'd2, 2'd2, 32'h00000005, 32'h00000005, 5'h00, 32'h00000005, 5'h04, 1'b0);
    endtask

    task automatic t_adda();
        expect_op("R7 adda long", 4'd3, 2'd2, 32'h0112B33C, 32'h2C34C11C, 5'h1F, 32'h2D477458, 5'h1F, 1'b0);
        expect_op("R7 adda word sext", 4'd3, 2'd1, 32'h0112B33C, 32'h2C34C11C, 5'h05, 32'h01127458, 5'h05, 1'b0);
    endtask

    task automatic t_mulu();
        expect_op("R8 mulu", 4'd4, 2'd1, 32'hA0120002, 32'h1234A678, 5'h13, 32'h00014CF0, 5'h10, 1'b0);
        expect_op("R8 mulu large", 4'd4, 2'd1, 32'hB11CA024, 32'h336B4105, 5'h00, 32'h28AC44B4, 5'h00, 1'b0);
    endtask

    task automatic t_divu();
        expect_op("R9 divu", 4'd5, 2'd1, 32'h28AC44B5, 32'h1C32A024, 5'h03, 32'h00014105, 5'h00, 1'b0);
        expect_op("R9 divu top quotient bit", 4'd5, 2'd1, 32'h00010003, 32'h00000002, 5'h10, 32'h00018001, 5'h18, 1'b0);
    endtask

    task automatic t_div_ovf();
        expect_op("R10 quotient too wide", 4'd5, 2'd1, 32'h00020000, 32'h00000001, 5'h1C, 32'h00020000, 5'h1E, 1'b1);
        expect_op("R10 zero divisor", 4'd5, 2'd1, 32'h00001234, 32'hFFFF0000, 5'h01, 32'h00001234, 5'h02, 1'b1);
    endtask

    task automatic t_swap();
        expect_op("R11 swap", 4'd6, 2'd2, 32'h12345678, 32'h0, 5'h13, 32'h56781234, 5'h10, 1'b0);
        expect_op("R11 swap negative", 4'd6, 2'd2, 32'h00008000, 32'h0, 5'h00, 32'h80000000, 5'h08, 1'b0);
    endtask

    task automatic t_lshift();
        expect_op("R12 lsl byte", 4'd7, 2'd0, 32'h123456C1, 32'h0, 5'h00, 32'h12345682, 5'h19, 1'b0);
        expect_op("R12 lsr word", 4'd8, 2'd1, 32'hFFFF0001, 32'h0, 5'h00, 32'hFFFF0000, 5'h15, 1'b0);
    endtask

    task automatic t_ashift();
        expect_op("R13 asr long", 4'd10, 2'd2, 32'h80000002, 32'h0, 5'h10, 32'hC0000001, 5'h08, 1'b0);
        expect_op("R13 asr word", 4'd10, 2'd1, 32'h12348001, 32'h0, 5'h00, 32'h1234C000, 5'h19, 1'b0);
        expect_op("R13 asl byte sign change", 4'd9, 2'd0, 32'h00000040, 32'h0, 5'h00, 32'h00000080, 5'h0A, 1'b0);
    endtask

    task automatic t_rotate();
        expect_op("R14 rol word", 4'd11, 2'd1, 32'h00008001, 32'h0, 5'h10, 32'h00000003, 5'h11, 1'b0);
        expect_op("R14 ror byte", 4'd12, 2'd0, 32'hFFFFFF01, 32'h0, 5'h00, 32'hFFFFFF80, 5'h09, 1'b0);
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        op = 4'd5; size = 2'd1; dst = 32'h28AC44B5; src = 32'h0000A024; ccr_in = 5'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 4'd0; dst = 32'h00000001; src = 32'h00000001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk("R2 start ignored while busy", result, 32'h00014105);
        lat = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done || busy) lat++;
        end
        chk("R2 no second operation", 32'(lat), 0);
    endtask

    task automatic t_unknown();
        expect_op("R2 unused code", 4'd14, 2'd0, 32'hDEADBEEF, 32'h1, 5'h0B, 32'hDEADBEEF, 5'h0B, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_adda();
        t_mulu();
        t_divu();
        t_div_ovf();
        t_swap();
        t_lshift();
        t_ashift();
        t_rotate();
        t_busy_ignore();
        t_unknown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule